// File: doc/BRIEF.md
# Paired-Byte Register Target on a Two-Wire Bus

This block is an I2C target that puts a bank of 16-bit registers behind an 8-bit register pointer. To select a register, a host runs a short write transaction that carries one pointer byte. It then fetches the register one byte at a time, using two separate single-byte read transactions. The first read returns the high byte and the second returns the low byte. The target keeps the whole word from the moment the first byte is sent, so the two halves always belong to the same value.

While a register has been only half read, the target rejects any new pointer byte with a NAK and keeps its current pointer. It still acknowledges its own address in both directions during that time, so the host can finish the pair.

Both bus lines are open-drain. The block only ever pulls a line low or releases it. It samples SCL and SDA with the system clock after a synchronizer. The register file sits outside the block: the pointer drives it, and it answers with a 16-bit word through a plain parallel port.

Top module: `i2c_pair_target`

## Requirements
- R1: The target acknowledges its 7-bit address 0x56 in both directions, with the R/W bit as the least significant bit of the address byte (0 = write, 1 = read). This holds even while a register is half read.
- R2: An address byte other than 0x56 gets no ACK. SDA then stays released for the rest of that transaction, including its data bytes, until the next START.
- R3: When no pair is pending, a write of one pointer byte is acknowledged and sets `reg_addr` to that byte. Odd and even values are accepted alike.
- R4: After a pointer is set, the first read returns bits 15:8 of the register word and the next read returns bits 7:0. Both bytes are sent MSB first. The word is captured when the high byte is sent, so a change of `reg_rdata` between the two reads does not alter the low byte.
- R5: While a pair is pending (high byte sent, low byte not yet sent), a pointer byte is answered with a NAK and `reg_addr` does not change.
- R6: Sending the low byte completes the pair. The next pointer byte is then accepted.
- R7: After reset, `reg_addr` is 0, no pair is pending and SDA is released. A read with no prior pointer write returns the high byte of register 0.
- R8: A STOP or repeated START in the middle of a byte abandons that byte. The pointer does not change and the pending-pair state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases it |
| scl_pull_low | output | 1 | SCL pull-down; always released (no clock stretching) |
| reg_addr | output | 8 | Current register pointer to the register file |
| reg_rdata | input | 16 | Register word at `reg_addr` |

## Verification
Several properties are checked on every cycle. SDA is only pulled during an acknowledge slot or a read byte. It is released right after a STOP. The pointer cannot move while a pair is pending. The pending flag rises and falls only when a read byte is loaded. Reset leaves SDA released and the pointer at zero. Other behaviours can only be shown by the bench's transaction scenarios: the high-then-low byte order, the capture of the word against a changing register file, the NAK of a pointer during a half-read pair, the silence toward other addresses, and the survival of the pending state across an abandoned byte.

// File: rtl/i2cp_pkg.sv
// Shared definitions for the paired-byte register target.
// Assumes the byte-oriented framing of the two-wire bus (8 data bits + ack).
package i2cp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_WR_BYTE  = 3'd3,
        ST_WR_ACK   = 3'd4,
        ST_RD_BYTE  = 3'd5,
        ST_IGNORE   = 3'd6
    } tgt_state_t;
endpackage

// File: rtl/i2cp_line_sync.sv
// Synchronizes SCL/SDA into the system clock domain and flags SCL edges
// and START/STOP conditions. Assumes the system clock is many times
// faster than SCL so every bus phase spans several samples.
module i2cp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;
    logic              scl_s;

    // Metastability chain, reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronized levels.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cp_pair_track.sv
// Tracks a two-byte fetch of one register word. On the first load it
// captures the word and offers the high byte; on the second it offers the
// captured low byte and closes the pair. Assumes load is a one-cycle pulse.
module i2cp_pair_track #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              pending,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] low_hold;

    // Pending flag and captured low half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            low_hold <= '0;
        end else if (load) begin
            pending <= ~pending;
            if (!pending) low_hold <= word_in[BYTE_W-1:0];
        end
    end

    // Byte presented for the read that is being loaded now.
    always_comb byte_out = pending ? low_hold : word_in[WORD_W-1 -: BYTE_W];
endmodule

// File: rtl/i2c_pair_target.sv
// Bus target exposing 16-bit registers through an 8-bit pointer, each word
// read as two single-byte read transactions (high then low). Refuses a new
// pointer while a pair is half read. Assumes a combinational register file
// answering reg_rdata for reg_addr in the same cycle; no clock stretching.
module i2c_pair_target
    import i2cp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h56,
    parameter int         PTR_W       = 8,
    parameter int         WORD_W      = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic              scl_pull_low,
    output logic [PTR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    tgt_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              sda_low;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              pend, pair_load;
    logic [BYTE_W-1:0] pair_byte;

    i2cp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cp_pair_track #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .load(pair_load), .word_in(reg_rdata),
        .pending(pend), .byte_out(pair_byte)
    );

    // A read byte is fetched at the end of the address acknowledge clock.
    always_comb pair_load = (state == ST_ADDR_ACK) && scl_fall && rw && !start_det && !stop_det;

    // Bus protocol sequencer: address match, pointer write, byte transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            sda_low  <= 1'b0;
            reg_addr <= '0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_low <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && bit_cnt != FULL) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == FULL) begin
                        if (state == ST_ADDR) begin
                            if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                rw      <= shreg[0];
                                sda_low <= 1'b1;
                                state   <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (!pend) begin
                            reg_addr <= shreg[PTR_W-1:0];
                            sda_low  <= 1'b1;
                            state    <= ST_WR_ACK;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            tx      <= pair_byte;
                            sda_low <= ~pair_byte[BYTE_W-1];
                            bit_cnt <= CNT_W'(1);
                            state   <= ST_RD_BYTE;
                        end else begin
                            sda_low <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_WR_BYTE;
                        end
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (bit_cnt == FULL) begin
                            sda_low <= 1'b0;
                            state   <= ST_IGNORE;
                        end else begin
                            sda_low <= ~tx[BYTE_W-2];
                            tx      <= {tx[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        sda_low <= 1'b0;
                        state   <= ST_IGNORE;
                    end
                end
                default: sda_low <= 1'b0;
            endcase
        end
    end

    // Open-drain outputs: only pull-downs, SCL never held.
    always_comb begin
        sda_pull_low = sda_low;
        scl_pull_low = 1'b0;
    end
endmodule

// File: rtl/i2cp_checker.sv
// Cycle-level properties of the paired-byte target, bound to its top.
module i2cp_checker
    import i2cp_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input tgt_state_t       state,
    input logic             pending,
    input logic             sda_pull_low,
    input logic             stop_det,
    input logic [PTR_W-1:0] reg_addr
);
    // R7: reset leaves the pointer at zero and SDA released.
    assert_reset_state_R7: assert property (@(posedge clk)
        !rst_n |=> (reg_addr == '0 && !sda_pull_low && !pending));

    // R5: a pending pair freezes the pointer.
    assert_ptr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(reg_addr));

    // R2: SDA is pulled only in an acknowledge slot or a read byte.
    assert_sda_only_when_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_low |-> (state == ST_ADDR_ACK || state == ST_WR_ACK || state == ST_RD_BYTE));

    // R8: a STOP releases SDA on the next cycle.
    assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_low);

    // R4: a pair opens only as a read byte is loaded.
    assert_pair_opens_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> state == ST_RD_BYTE);

    // R6: a pair closes only as the second read byte is loaded.
    assert_pair_closes_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> state == ST_RD_BYTE);
endmodule

bind i2c_pair_target i2cp_checker #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .pending(pend),
    .sda_pull_low(sda_pull_low), .stop_det(stop_det), .reg_addr(reg_addr)
);

// File: tb/i2c_pair_target_bench.sv
// Bench: bus master tasks plus a behavioural model of pointer, pending
// pair and captured word; reg_addr and SDA release are compared every
// clock while the bus is quiet.
module i2c_pair_target_bench;
    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_pull_low, scl_pull_low;
    logic [7:0]  reg_addr;
    logic [15:0] reg_rdata;
    logic [7:0]  salt = 8'h00;
    wire         sda_bus = sda_m & ~sda_pull_low;
    wire         scl_bus = scl_m & ~scl_pull_low;

    int errors = 0, checks = 0;
    bit quiet = 1'b0;
    bit done = 1'b0;

    // model state
    logic [7:0]  m_ptr = 8'h00;
    bit          m_pend = 1'b0;
    logic [15:0] m_word = 16'h0;

    always #10 clk = ~clk;

    function automatic logic [15:0] regf(input logic [7:0] a, input logic [7:0] s);
        return {a ^ 8'h3C ^ s, ~a ^ s};
    endfunction
    assign reg_rdata = regf(reg_addr, salt);

    i2c_pair_target u_i2c_pair_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .sda_pull_low(sda_pull_low), .scl_pull_low(scl_pull_low),
        .reg_addr(reg_addr), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every-clock comparison while the bus is idle
    always @(negedge clk) begin
        if (rst_n && quiet) begin
            chk(reg_addr == m_ptr, "R3/R5 pointer", reg_addr, m_ptr);
            chk(!sda_pull_low, "R2 sda released", sda_pull_low, 0);
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H);
        sda_m = 1'b0; wclk(H); scl_m = 1'b0; wclk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(H); scl_m = 1'b1; wclk(H); sda_m = 1'b1; wclk(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wclk(H); scl_m = 1'b1; wclk(H); scl_m = 1'b0; wclk(2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H / 2);
        b = sda_bus; wclk(H / 2); scl_m = 1'b0; wclk(2);
    endtask

    task automatic put_byte(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(1'b1);
    endtask

    task automatic ptr_write(input logic [7:0] p, input logic [6:0] dev, input string req);
        bit a1, a2;
        bit exp_addr = (dev == 7'h56);
        bit exp_data = exp_addr && !m_pend;
        quiet = 1'b0;
        bus_start();
        put_byte({dev, 1'b0}, a1);
        put_byte(p, a2);
        bus_stop();
        chk(a1 == exp_addr, {req, " address ack (R1/R2)"}, a1, exp_addr);
        chk(a2 == exp_data, {req, " pointer ack"}, a2, exp_data);
        if (exp_data) m_ptr = p;
        quiet = 1'b1;
        wclk(4);
    endtask

    task automatic data_read(input string req, input bit with_start);
        bit a;
        logic [7:0] v;
        logic [7:0] exp;
        quiet = 1'b0;
        if (with_start) bus_start();
        put_byte({7'h56, 1'b1}, a);
        chk(a, {req, " read address ack (R1)"}, a, 1);
        if (!m_pend) begin
            m_word = regf(m_ptr, salt);
            exp = m_word[15:8];
        end else begin
            exp = m_word[7:0];
        end
        get_byte(v);
        bus_stop();
        m_pend = !m_pend;
        chk(v == exp, {req, " read byte"}, v, exp);
        quiet = 1'b1;
        wclk(4);
    endtask

    initial begin
        wclk(200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit a1, a2;
        logic b;
        wclk(5);
        rst_n = 1'b1;
        wclk(2);
        // R7: reset state
        chk(reg_addr == 8'h00, "R7 reset pointer", reg_addr, 0);
        chk(!sda_pull_low, "R7 reset sda", sda_pull_low, 0);
        quiet = 1'b1;
        // R7: read with no pointer write gives register 0 high, then low (R4)
        data_read("R7 first read reg0", 1'b1);
        data_read("R4 low byte reg0", 1'b1);
        // R3: odd pointer; R4 word captured across salt change
        ptr_write(8'h13, 7'h56, "R3 odd pointer");
        data_read("R4 high 0x13", 1'b1);
        salt = 8'h5A;
        data_read("R4 captured low 0x13", 1'b1);
        // R5: pointer refused while pending; R1 address still acked
        ptr_write(8'h40, 7'h56, "R3 even pointer");
        data_read("R4 high 0x40", 1'b1);
        ptr_write(8'h41, 7'h56, "R5 refused pointer");
        chk(reg_addr == 8'h40, "R5 pointer kept", reg_addr, 8'h40);
        data_read("R5 low 0x40", 1'b1);
        // R6: pair done, pointer accepted
        ptr_write(8'h41, 7'h56, "R6 accepted pointer");
        chk(reg_addr == 8'h41, "R6 pointer set", reg_addr, 8'h41);
        // R2: foreign addresses
        ptr_write(8'h99, 7'h57, "R2 foreign write");
        quiet = 1'b0;
        bus_start();
        put_byte({7'h55, 1'b1}, a1);
        for (int i = 0; i < 8; i++) get_bit(b);
        chk(!a1, "R2 foreign read ack", a1, 0);
        chk(b == 1'b1, "R2 no data on foreign read", b, 1);
        bus_stop();
        quiet = 1'b1;
        // R8: abandoned bytes keep pending state
        data_read("R8 high 0x41", 1'b1);
        quiet = 1'b0;
        bus_start();
        put_byte({7'h56, 1'b0}, a1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        chk(a1, "R8 address ack before abort (R1)", a1, 1);
        chk(reg_addr == 8'h41, "R8 pointer after stop abort", reg_addr, 8'h41);
        bus_start();
        put_byte({7'h56, 1'b0}, a2);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        data_read("R8 low after repeated start", 1'b1);
        chk(reg_addr == 8'h41, "R8 pointer after restart abort", reg_addr, 8'h41);
        // R8: abandoned pointer with no pair pending leaves pointer
        quiet = 1'b0;
        bus_start();
        put_byte({7'h56, 1'b0}, a1);
        put_bit(1'b0); put_bit(1'b0);
        bus_stop();
        quiet = 1'b1;
        wclk(4);
        chk(reg_addr == 8'h41, "R8 pointer after partial write", reg_addr, 8'h41);
        ptr_write(8'h02, 7'h56, "R6 pointer after abort");
        data_read("R4 high 0x02", 1'b1);
        data_read("R4 low 0x02", 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule